// File: doc/BRIEF.md
# Sample Clock Phase Selector

This block derives a sample-rate clock from a reference clock that runs at eight times the sample rate. A free-running slot counter splits each sample period into eight equal slots of 45 degrees each. The output clock is high for the first half of the period and low for the second half. It can then be delayed by zero to three slots and inverted on request. Taken together, these settings place the rising edge at any of the eight 45-degree positions.

A stabilizer-enable input controls whether the slot delay is used. When it is low, the delay code has no effect, but the inversion still applies. The block also drives a one-cycle data-update strobe. This strobe marks the falling edge of the unshifted clock, which is the point where full-rate data would change, so the rising edge of the unshifted clock falls in the middle of the data eye.

Control inputs are sampled only at the period boundary, so a whole period always runs under a single setting. After reset the output stays quiet for one full period before the first real cycle begins.

Top module: `clk_phase_sel`

## Requirements
- R1: While `rst_n` is low at a reference edge, both `samp_clk_o` and `data_upd_o` are low after that edge, and the slot position returns to zero.
- R2: For the first eight reference cycles after reset is released, `samp_clk_o` and `data_upd_o` stay low.
- R3: After that, `samp_clk_o` repeats every eight reference cycles and is high for exactly four of them.
- R4: `data_upd_o` is a single-cycle pulse, once per period, in the cycle where the unshifted clock would fall. It comes four cycles after the unshifted rising edge.
- R5: With `stab_en_i`=1 and `clk_inv_i`=0, the phase code 0/1/2/3 delays the rising edge by 0/1/2/3 slots. The rise therefore comes 4/5/6/7 cycles after the strobe, which gives 0, 45, 90 and 135 degrees.
- R6: `clk_inv_i`=1 inverts the output, which adds four slots. With the stabilizer on, codes 0/1/2/3 give 180/225/270/315 degrees, so the rise comes 0/1/2/3 cycles after the strobe.
- R7: With `stab_en_i`=0, the phase code is ignored. The rise comes 4 cycles after the strobe with `clk_inv_i`=0, and in the strobe cycle itself with `clk_inv_i`=1.
- R8: The control inputs are sampled only at the reference edge where the slot count wraps from 7 to 0. Those values govern the following period. Changes at any other edge have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, eight times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_code_i | input | 2 | Slot delay code: 0..3 slots of 45 degrees |
| clk_inv_i | input | 1 | 1 inverts the output clock (adds 180 degrees) |
| stab_en_i | input | 1 | 1 applies the slot delay; 0 forces zero delay |
| samp_clk_o | output | 1 | Phase-selected sample clock |
| data_upd_o | output | 1 | One-cycle strobe at the unshifted falling edge |

## Verification
A wrong slot count or a wrongly latched delay appears in the distance between the strobe and the next rising edge of the output. A mismatch shows up within one period, which is eight reference cycles. A setting that is captured at the wrong edge changes the waveform in the middle of a period, and the cycle-by-cycle model catches it in that cycle. A broken start-up gate shows up as an output edge during the first eight cycles after reset.

// File: rtl/clk_phase_pkg.sv
// Package: shared helpers for the sample clock phase selector.
// Assumes the slot count is a power of two and that the delay code is
// narrower than the slot counter by one bit.
package clk_phase_pkg;

    // Total slot delay for a setting, in slots, modulo the slot count.
    function automatic int unsigned slot_delay(
        input int unsigned code,
        input bit          invert,
        input bit          stab_on,
        input int unsigned slots
    );
        int unsigned d;
        d = stab_on ? code : 0;
        if (invert) d = d + slots / 2;
        return d % slots;
    endfunction

endpackage

// File: rtl/cps_slot_counter.sv
// Module: free-running slot counter.
// Counts reference cycles modulo 2**CNT_W and flags the last slot of the
// period. Assumes a synchronous active-low reset that forces slot zero.
module cps_slot_counter #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] LAST_SLOT = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Advance one slot per reference cycle; wrap back to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNT_W'(1);
    end

    // Flag the final slot so the next edge is the period boundary.
    always_comb begin
        wrap_o = (cnt_q == LAST_SLOT);
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/cps_ctrl_capture.sv
// Module: control capture at the period boundary.
// Samples the phase code, invert and stabilizer inputs only on the edge
// where the slot counter wraps. It turns them into one slot delay and
// arms the output after the first full period. Assumes SEL_W < CNT_W.
module cps_ctrl_capture #(
    parameter int unsigned CNT_W = 3,
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap_i,
    input  logic [SEL_W-1:0] code_i,
    input  logic             inv_i,
    input  logic             stab_i,
    output logic [CNT_W-1:0] shift_o,
    output logic             armed_o
);

    localparam int unsigned SLOTS = 1 << CNT_W;

    logic [CNT_W-1:0] shift_d;
    logic [CNT_W-1:0] shift_q;
    logic             armed_q;

    // Combine code, stabilizer gate and inversion into one slot delay.
    always_comb begin
        shift_d = CNT_W'(clk_phase_pkg::slot_delay(
                      int'(code_i), inv_i, stab_i, SLOTS));
    end

    // Take a new setting only at the boundary; hold it for the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            armed_q <= 1'b0;
        end else if (wrap_i) begin
            shift_q <= shift_d;
            armed_q <= 1'b1;
        end
    end

    assign shift_o = shift_q;
    assign armed_o = armed_q;

endmodule

// File: rtl/cps_wave_gen.sv
// Module: output waveform and data strobe generator.
// Builds the half-high square wave from the slot count minus the latched
// delay, and a strobe at the unshifted falling slot. Both outputs are
// registered with the same latency, so they stay aligned.
module cps_wave_gen #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] shift_i,
    input  logic             armed_i,
    output logic             clk_o,
    output logic             strobe_o
);

    localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

    logic [CNT_W-1:0] rel_slot;
    logic             level;
    logic             clk_q;
    logic             strobe_q;

    // Slot position relative to the delayed rising edge.
    always_comb begin
        rel_slot = cnt_i - shift_i;
        level    = ~rel_slot[CNT_W-1];
    end

    // Register clock level and strobe; hold both low until armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            clk_q    <= armed_i & level;
            strobe_q <= armed_i & (cnt_i == HALF);
        end
    end

    assign clk_o    = clk_q;
    assign strobe_o = strobe_q;

endmodule

// File: rtl/clk_phase_sel.sv
// Module: sample clock phase selector (top).
// Divides a reference clock eight ways (for CNT_W=3) and outputs a
// sample clock with a selectable 45-degree phase and polarity, plus a
// data-update strobe. Assumes a synchronous active-low reset.
module clk_phase_sel #(
    parameter  int unsigned CNT_W = 3,
    localparam int unsigned SEL_W = CNT_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] phase_code_i,
    input  logic             clk_inv_i,
    input  logic             stab_en_i,
    output logic             samp_clk_o,
    output logic             data_upd_o
);

    logic [CNT_W-1:0] slot_cnt;
    logic             slot_wrap;
    logic [CNT_W-1:0] eff_shift;
    logic             armed;

    cps_slot_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (slot_cnt),
        .wrap_o (slot_wrap)
    );

    cps_ctrl_capture #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap_i  (slot_wrap),
        .code_i  (phase_code_i),
        .inv_i   (clk_inv_i),
        .stab_i  (stab_en_i),
        .shift_o (eff_shift),
        .armed_o (armed)
    );

    cps_wave_gen #(.CNT_W(CNT_W)) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_i    (slot_cnt),
        .shift_i  (eff_shift),
        .armed_i  (armed),
        .clk_o    (samp_clk_o),
        .strobe_o (data_upd_o)
    );

endmodule

// File: rtl/clk_phase_sel_chk.sv
// Checker: temporal properties of the sample clock phase selector.
// Attached to every instance of the top through the bind below.
module clk_phase_sel_chk #(
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             samp_clk_o,
    input logic             data_upd_o,
    input logic [CNT_W-1:0] slot_cnt,
    input logic [CNT_W-1:0] eff_shift,
    input logic             armed
);

    localparam int unsigned SLOTS = 1 << CNT_W;

    logic [CNT_W:0] gap_q;
    logic           seen_q;

    // Count reference cycles since the last strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (data_upd_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != {(CNT_W+1){1'b1}}) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R1: a reset edge leaves both outputs low.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!samp_clk_o && !data_upd_o));

    // R2: nothing leaves the block before the first full period.
    a_r2_quiet_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (!samp_clk_o && !data_upd_o));

    // R3: strobes are exactly one period apart.
    a_r3_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (data_upd_o && seen_q) |-> (gap_q == (CNT_W+1)'(SLOTS - 1)));

    // R4: the strobe lasts a single reference cycle.
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        data_upd_o |=> !data_upd_o);

    // R8: the latched delay moves only at the period boundary.
    a_r8_shift_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(eff_shift) |-> (slot_cnt == '0));

endmodule

bind clk_phase_sel clk_phase_sel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_clk_o (samp_clk_o),
    .data_upd_o (data_upd_o),
    .slot_cnt   (slot_cnt),
    .eff_shift  (eff_shift),
    .armed      (armed)
);

// File: tb/clk_phase_sel_test.sv
`timescale 1ns/1ps
// Bench: cycle-by-cycle model of the phase selector plus rising-edge
// delay measurements for all sixteen control settings.
module clk_phase_sel_test;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] phase_code = 2'd0;
    logic       clk_inv = 1'b0;
    logic       stab_en = 1'b0;
    logic       samp_clk;
    logic       data_upd;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int     k = 0;
    int     app_d = 0;
    logic [3:0] last_snap = '0;
    bit     prev_out = 0;
    int     last_upd_k = -1;
    bit     got_rise = 0;
    string  phase_tag = "R3";

    clk_phase_sel uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_code_i (phase_code),
        .clk_inv_i    (clk_inv),
        .stab_en_i    (stab_en),
        .samp_clk_o   (samp_clk),
        .data_upd_o   (data_upd)
    );

    always #5 clk = ~clk;

    // Expected slot delay for a {stab, inv, code} setting.
    function automatic int delay_of(logic [3:0] c);
        int d;
        d = c[3] ? int'(c[1:0]) : 0;
        if (c[2]) d = d + N / 2;
        return d % N;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d (k=%0d)", tag, act, exp, k);
        end
    endtask

    // One reference cycle: sample after the edge and compare to the model.
    task automatic step();
        logic [3:0] snap;
        int  p;
        bit  arm;
        bit  exp_o;
        bit  exp_u;
        snap = {stab_en, clk_inv, phase_code};
        @(negedge clk);
        if (!rst_n) begin
            k = 0;
            app_d = 0;
            check(samp_clk == 1'b0, "R1 clock", int'(samp_clk), 0);
            check(data_upd == 1'b0, "R1 strobe", int'(data_upd), 0);
            prev_out = 0;
            last_upd_k = -1;
            got_rise = 0;
        end else begin
            k++;
            p = (k - 1) % N;
            arm = (k > N);
            if (arm && p == 0) app_d = delay_of(last_snap);
            exp_o = arm && (((p - app_d + N) % N) < N / 2);
            exp_u = arm && (p == N / 2);
            check(samp_clk == exp_o, (k <= N) ? "R2 clock" : phase_tag,
                  int'(samp_clk), int'(exp_o));
            check(data_upd == exp_u, (k <= N) ? "R2 strobe" : "R4",
                  int'(data_upd), int'(exp_u));
            if (data_upd) last_upd_k = k;
            got_rise = !prev_out && samp_clk;
            prev_out = samp_clk;
        end
        last_snap = snap;
    endtask

    // Measure cycles from a fresh strobe to the next rising edge.
    task automatic meas_rise(int exp, string tag);
        int start;
        bit found;
        start = k + 1;
        found = 0;
        for (int i = 0; i < 3 * N && !found; i++) begin
            step();
            if (got_rise && last_upd_k >= start) begin
                found = 1;
                check(k - last_upd_k == exp, tag, k - last_upd_k, exp);
            end
        end
        if (!found) check(0, tag, -1, exp);
    endtask

    task automatic set_cfg(logic [3:0] c);
        {stab_en, clk_inv, phase_code} = c;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset holds the outputs low.
        repeat (4) step();
        set_cfg(4'b1000);
        rst_n = 1'b1;
        // R2 then R3 in steady state.
        phase_tag = "R3";
        repeat (3 * N) step();
        // R5, R6, R7: sweep every setting and measure the rise delay.
        for (int c = 0; c < 16; c++) begin
            logic [3:0] cf;
            int exp;
            string tag;
            cf = 4'(c);
            set_cfg(cf);
            phase_tag = "R8";
            repeat (2 * N + 3) step();
            exp = (delay_of(cf) + N / 2) % N;
            tag = !cf[3] ? "R7" : (cf[2] ? "R6" : "R5");
            meas_rise(exp, tag);
        end
        // R8: a glitch on the controls in mid-period is ignored.
        set_cfg(4'b1001);
        repeat (2 * N) step();
        while (!data_upd) step();
        set_cfg(4'b1110);
        step();
        step();
        set_cfg(4'b1001);
        repeat (2 * N) step();
        // R8: random control changes at random points in the period.
        for (int i = 0; i < 60; i++) begin
            set_cfg(4'($urandom_range(0, 15)));
            repeat ($urandom_range(1, 11)) step();
        end
        // R1 and R2 again: reset in mid-run.
        rst_n = 1'b0;
        repeat (2) step();
        set_cfg(4'b1111);
        rst_n = 1'b1;
        phase_tag = "R3";
        repeat (3 * N) step();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule